// File: doc/BRIEF.md
# Multi-Channel DMA Start and Queue Control

This block sits between the CPU register port and ten DMA transfer engines. It holds one 32-bit control word per channel and two global words: a control word whose bit 0 is the master enable, and a gating word whose bit 16 suspends the whole controller. Each CPU write to a channel word is filtered by rules that depend on whether that channel is already running (start bit 8 of its word is set) and on whether the controller is suspended. A write that asks a channel to run either launches it at once or, while the controller is disabled or suspended, marks it pending in a 16-bit queue.

Pending channels are launched later, when a write turns the master enable on or lifts the suspend. Stopping a running channel by writing 0 to its start bit emits an interrupt-clear pulse for that channel (plus a paired position for two of the channels) and withdraws any pending launch. The block drives one start pulse per channel and one interrupt-clear pulse per queue position, both one clock wide and registered.

Top module: `dma_launch_ctrl`

## Requirements
- R1: A write to a channel whose stored start bit (bit 8) is 0 stores the full word; if the written bit 8 is 1 while enable (control bit 0) is 1 and suspend (gating bit 16) is 0, that channel's start_pulse bit is high for exactly the one cycle after the write.
- R2: A write to an idle channel with bit 8 set while enable is 0 or suspend is 1 produces no start pulse and marks the channel pending.
- R3: A write to a running channel while suspend is 0 changes nothing but bit 8: writing bit 8 = 0 clears only that bit, writing bit 8 = 1 leaves the word unchanged.
- R4: A write to a running channel while suspend is 1 replaces bits 15:0 with the written value and keeps bits 31:16.
- R5: A write of bit 8 = 0 to a running channel (suspended or not) pulses irq_clr at that channel's position in the cycle after the write and removes the channel from the pending set.
- R6: Stopping channel 1 also pulses and clears position 10; stopping channel 2 also pulses and clears position 11.
- R7: A write that changes enable from 0 to 1, or suspend from 1 to 0, launches every pending channel whose bit 8 is still set, all in the cycle after that write, and removes them from the pending set.
- R8: Launching from the pending set happens only if, after the write, enable is 1 and suspend is 0; otherwise pending channels stay pending, and a global write without such a transition launches nothing.
- R9: Reads are combinational: address 0 to 9 return the channel words, 10 the control word, 11 the gating word, any other address 0.
- R10: After reset all stored words, the pending set and both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0..9 channel, 10 control, 11 gating) |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data |
| start_pulse | output | NCH | One-cycle launch per channel |
| irq_clr | output | QW | One-cycle interrupt-clear per queue position |

## Verification
The bench builds the block with its default parameters: ten channels and a sixteen-position queue. These values put the paired positions 10 and 11 inside the queue, so the extra clears tied to channels 1 and 2 show up on irq_clr, and they let channel 9 exercise the top of the channel range. The stimulus launches channels directly, blocks writes to running channels both with and without suspend, fills the pending set while disabled or suspended, and releases it through enable and suspend edges. It also covers edges that leave the controller still gated and global writes that cause no transition.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int WORD_W      = 32;
  localparam int HALF_W      = 16;
  localparam int START_BIT   = 8;
  localparam int ENABLE_BIT  = 0;
  localparam int SUSPEND_BIT = 16;
  localparam int MASK_W      = 32;
  localparam int PAIR_A_CH   = 1;
  localparam int PAIR_A_POS  = 10;
  localparam int PAIR_B_CH   = 2;
  localparam int PAIR_B_POS  = 11;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic enabled;
    logic suspended;
  } gate_t;

  // Suspended write: new low half, old tag half.
  function automatic word_t keep_tag(word_t cur, word_t wr);
    return {cur[WORD_W-1:HALF_W], wr[HALF_W-1:0]};
  endfunction

  // Running, not suspended: only the start bit may fall.
  function automatic word_t drop_start(word_t cur);
    word_t r;
    r = cur;
    r[START_BIT] = 1'b0;
    return r;
  endfunction

  // Positions cleared when channel ch is stopped.
  function automatic logic [MASK_W-1:0] stop_mask(int ch);
    logic [MASK_W-1:0] m;
    m = '0;
    m[ch] = 1'b1;
    if (ch == PAIR_A_CH) m[PAIR_A_POS] = 1'b1;
    if (ch == PAIR_B_CH) m[PAIR_B_POS] = 1'b1;
    return m;
  endfunction

  function automatic logic may_run(gate_t g);
    return g.enabled && !g.suspended;
  endfunction
endpackage

// File: rtl/dlc_chan_slot.sv
module dlc_chan_slot
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  word_t wr_data,
  input  gate_t gate,
  output word_t word,
  output logic  start_now,
  output logic  queue_req,
  output logic  stop_now
);
  word_t word_q, word_d;
  logic  active;
  logic  wr_start;

  assign active   = word_q[START_BIT];
  assign wr_start = wr_data[START_BIT];
  assign word     = word_q;

  always_comb begin
    word_d    = word_q;
    start_now = 1'b0;
    queue_req = 1'b0;
    stop_now  = 1'b0;
    if (sel) begin
      if (!active) begin
        word_d = wr_data;
        if (wr_start) begin
          if (may_run(gate)) start_now = 1'b1;
          else               queue_req = 1'b1;
        end
      end else if (gate.suspended) begin
        word_d   = keep_tag(word_q, wr_data);
        stop_now = !wr_start;
      end else if (!wr_start) begin
        word_d   = drop_start(word_q);
        stop_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/dlc_global_regs.sv
module dlc_global_regs
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_ctrl,
  input  logic  sel_gate,
  input  word_t wr_data,
  output word_t ctrl_word,
  output word_t gate_word,
  output gate_t gate_now,
  output gate_t gate_next,
  output logic  replay_evt
);
  word_t ctrl_q, gate_q;
  logic  en_rise, susp_fall;

  assign ctrl_word = ctrl_q;
  assign gate_word = gate_q;

  assign gate_now.enabled   = ctrl_q[ENABLE_BIT];
  assign gate_now.suspended = gate_q[SUSPEND_BIT];

  assign gate_next.enabled   = sel_ctrl ? wr_data[ENABLE_BIT]  : ctrl_q[ENABLE_BIT];
  assign gate_next.suspended = sel_gate ? wr_data[SUSPEND_BIT] : gate_q[SUSPEND_BIT];

  assign en_rise    = sel_ctrl && !ctrl_q[ENABLE_BIT] && wr_data[ENABLE_BIT];
  assign susp_fall  = sel_gate && gate_q[SUSPEND_BIT] && !wr_data[SUSPEND_BIT];
  assign replay_evt = en_rise || susp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gate_q <= '0;
    end else begin
      if (sel_ctrl) ctrl_q <= wr_data;
      if (sel_gate) gate_q <= wr_data;
    end
  end
endmodule

// File: rtl/dlc_pend_queue.sv
module dlc_pend_queue
  import dlc_pkg::*;
#(
  parameter int NCH = 10,
  parameter int QW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [QW-1:0]  clr_mask,
  input  logic           replay_evt,
  input  gate_t          gate_next,
  input  logic [NCH-1:0] chan_active,
  output logic [QW-1:0]  pend,
  output logic [NCH-1:0] replay_vec
);
  logic [QW-1:0] pend_q, set_w, rep_w;

  assign pend = pend_q;

  for (genvar i = 0; i < NCH; i++) begin : g_rep
    assign replay_vec[i] = replay_evt && may_run(gate_next) && pend_q[i] && chan_active[i];
  end

  always_comb begin
    set_w = '0;
    rep_w = '0;
    set_w[NCH-1:0] = set_vec;
    rep_w[NCH-1:0] = replay_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | set_w) & ~clr_mask & ~rep_w;
  end
endmodule

// File: rtl/dma_launch_ctrl.sv
module dma_launch_ctrl
  import dlc_pkg::*;
#(
  parameter int NCH    = 10,
  parameter int QW     = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    start_pulse,
  output logic [QW-1:0]     irq_clr
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(NCH + 1);

  logic [NCH-1:0][WORD_W-1:0] chan_word;
  logic [NCH-1:0] start_now, queue_req, stop_now, chan_active, replay_vec;
  logic [QW-1:0]  clr_mask, pend;
  word_t          ctrl_word, gate_word;
  gate_t          gate_now, gate_next;
  logic           replay_evt;
  logic           en_now, susp_now;
  logic [NCH-1:0] start_q;
  logic [QW-1:0]  clr_q;

  assign en_now   = gate_now.enabled;
  assign susp_now = gate_now.suspended;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel;
    assign sel            = wr_en && (wr_addr == ADDR_W'(i));
    assign chan_active[i] = chan_word[i][START_BIT];
    dlc_chan_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .wr_data   (wr_data),
      .gate      (gate_now),
      .word      (chan_word[i]),
      .start_now (start_now[i]),
      .queue_req (queue_req[i]),
      .stop_now  (stop_now[i])
    );
  end

  dlc_global_regs u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ctrl   (wr_en && wr_addr == CTRL_ADDR),
    .sel_gate   (wr_en && wr_addr == GATE_ADDR),
    .wr_data    (wr_data),
    .ctrl_word  (ctrl_word),
    .gate_word  (gate_word),
    .gate_now   (gate_now),
    .gate_next  (gate_next),
    .replay_evt (replay_evt)
  );

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NCH; i++) begin
      if (stop_now[i]) clr_mask = clr_mask | QW'(stop_mask(i));
    end
  end

  dlc_pend_queue #(.NCH(NCH), .QW(QW)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (queue_req),
    .clr_mask    (clr_mask),
    .replay_evt  (replay_evt),
    .gate_next   (gate_next),
    .chan_active (chan_active),
    .pend        (pend),
    .replay_vec  (replay_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      clr_q   <= '0;
    end else begin
      start_q <= start_now | replay_vec;
      clr_q   <= clr_mask;
    end
  end

  assign start_pulse = start_q;
  assign irq_clr     = clr_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = chan_word[i];
    end
    if (rd_addr == CTRL_ADDR) rd_data = ctrl_word;
    if (rd_addr == GATE_ADDR) rd_data = gate_word;
  end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int NCH    = 10,
  parameter int QW     = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [NCH-1:0]    start_pulse,
  input logic [QW-1:0]     irq_clr,
  input logic              en_now,
  input logic              susp_now,
  input logic [NCH*32-1:0] words
);
  logic chan_wr;
  assign chan_wr = wr_en && (wr_addr < ADDR_W'(NCH));

  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_pulse) |-> $past(wr_en)); // R1

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_pulse) |-> (en_now && !susp_now)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse & $past(start_pulse)) == '0); // R1

  AST_CLR_AFTER_CHAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> $past(chan_wr)); // R5

  if (NCH > 2 && QW > 11) begin : g_pair
    AST_PAIR_A: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[1] |-> irq_clr[10]); // R6
    AST_PAIR_B: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[2] |-> irq_clr[11]); // R6
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [31:0] w;
    logic        sel;
    assign w   = words[i*32 +: 32];
    assign sel = wr_en && (wr_addr == ADDR_W'(i));

    AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && w[8] && susp_now) |=> (w[31:16] == $past(w[31:16]))); // R4

    AST_LOCKED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && w[8] && !susp_now && wr_data[8]) |=> $stable(w)); // R3
  end
endmodule

bind dma_launch_ctrl dlc_checker #(.NCH(NCH), .QW(QW), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .start_pulse (start_pulse),
  .irq_clr     (irq_clr),
  .en_now      (en_now),
  .susp_now    (susp_now),
  .words       (chan_word)
);

// File: tb/dma_launch_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_launch_ctrl_tb_top;
  localparam int NCH = 10;
  localparam int QW  = 16;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NCH-1:0] start_pulse;
  logic [QW-1:0]  irq_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_launch_ctrl #(.NCH(NCH), .QW(QW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start_pulse(start_pulse), .irq_clr(irq_clr)
  );

  // Reference state kept from the requirements.
  logic [31:0] m_word [NCH];
  logic [31:0] m_ctrl, m_gate;
  logic [QW-1:0] m_pend;

  logic [NCH-1:0] exp_st [$];
  logic [QW-1:0]  exp_cl [$];
  string          exp_tag [$];

  task automatic note(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic replay(output logic [NCH-1:0] st);
    st = '0;
    if (m_ctrl[0] && !m_gate[16]) begin
      for (int c = 0; c < NCH; c++) begin
        if (m_pend[c] && m_word[c][8]) begin
          st[c] = 1'b1;
          m_pend[c] = 1'b0;
        end
      end
    end
  endtask

  task automatic model(int a, logic [31:0] d, output logic [NCH-1:0] st, output logic [QW-1:0] cl);
    logic [31:0] old;
    bit stop;
    st = '0; cl = '0; stop = 0;
    if (a < NCH) begin
      if (!m_word[a][8]) begin
        m_word[a] = d;
        if (d[8]) begin
          if (m_ctrl[0] && !m_gate[16]) st[a] = 1'b1;
          else m_pend[a] = 1'b1;
        end
      end else if (m_gate[16]) begin
        m_word[a] = {m_word[a][31:16], d[15:0]};
        stop = !d[8];
      end else if (!d[8]) begin
        m_word[a][8] = 1'b0;
        stop = 1;
      end
      if (stop) begin
        cl[a] = 1'b1;
        if (a == 1) cl[10] = 1'b1;
        if (a == 2) cl[11] = 1'b1;
        m_pend = m_pend & ~cl;
      end
    end else if (a == NCH) begin
      old = m_ctrl;
      m_ctrl = d;
      if (!old[0] && d[0]) replay(st);
    end else if (a == NCH + 1) begin
      old = m_gate;
      m_gate = d;
      if (old[16] && !d[16]) replay(st);
    end
  endtask

  // Driver: called at a falling edge, leaves at the next falling edge.
  task automatic wr(int a, logic [31:0] d, string tag);
    logic [NCH-1:0] st;
    logic [QW-1:0]  cl;
    model(a, d, st, cl);
    exp_st.push_back(st);
    exp_cl.push_back(cl);
    exp_tag.push_back(tag);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    rd_addr = AW'(a);
    #1;
    note(rd_data === exp, tag, rd_data, exp);
  endtask

  // Monitor: result of a write appears after the edge that samples it.
  initial begin
    logic [NCH-1:0] st;
    logic [QW-1:0]  cl;
    string t;
    forever begin
      @(posedge clk);
      if (wr_en) begin
        #5;
        st = exp_st.pop_front();
        cl = exp_cl.pop_front();
        t  = exp_tag.pop_front();
        note(start_pulse === st, {t, " start"}, 32'(start_pulse), 32'(st));
        note(irq_clr === cl, {t, " irq_clr"}, 32'(irq_clr), 32'(cl));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_word[c] = '0;
    m_ctrl = '0; m_gate = '0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    note(start_pulse === '0, "R10 start", 32'(start_pulse), 0);
    note(irq_clr === '0, "R10 irq_clr", 32'(irq_clr), 0);
    rd(0, 32'h0, "R10 ch0");
    rd(NCH, 32'h0, "R10 ctrl");
    rd(NCH + 1, 32'h0, "R10 gate");

    // R1 direct launch
    wr(NCH, 32'h0000_0001, "R9 enable on");
    rd(NCH, 32'h0000_0001, "R9 ctrl read");
    wr(0, 32'hABCD_0110, "R1 launch ch0");
    rd(0, 32'hABCD_0110, "R1 word stored");
    // R3 stop clears only bit 8, R5 clear pulse
    wr(0, 32'h1234_00FF, "R5 stop ch0");
    rd(0, 32'hABCD_0010, "R3 only start bit falls");
    // R3 writes with bit 8 set are ignored
    wr(3, 32'h0000_0101, "R1 launch ch3");
    wr(3, 32'h5555_01FF, "R3 ignored write");
    rd(3, 32'h0000_0101, "R3 word unchanged");

    // R4 suspended write to running channel
    wr(NCH + 1, 32'h0001_0000, "R9 suspend on");
    rd(NCH + 1, 32'h0001_0000, "R9 gate read");
    wr(3, 32'h7777_01A5, "R4 suspended keep run");
    rd(3, 32'h0000_01A5, "R4 tag kept");
    wr(3, 32'h7777_0042, "R5 suspended stop ch3");
    rd(3, 32'h0000_0042, "R4 low half stored");

    // R2 queue while suspended, R7 release on suspend fall
    wr(5, 32'h0000_0100, "R2 queue ch5");
    wr(7, 32'h0009_0100, "R2 queue ch7");
    rd(7, 32'h0009_0100, "R2 word stored");
    wr(NCH + 1, 32'h0001_0000, "R8 no edge rewrite");
    wr(NCH + 1, 32'h0000_0000, "R7 resume replays");

    // disabled: queue 1, 2, 9 then stop 1 and 2
    wr(NCH, 32'h0000_0000, "R8 disable");
    wr(1, 32'h0000_0100, "R2 queue ch1");
    wr(2, 32'h0000_0100, "R2 queue ch2");
    wr(9, 32'h0000_0100, "R2 queue ch9");
    wr(1, 32'h0000_0000, "R6 stop ch1");
    wr(2, 32'h0000_0000, "R6 stop ch2");
    wr(NCH + 1, 32'h0001_0000, "R8 suspend while off");
    wr(NCH, 32'h0000_0001, "R8 enable but suspended");
    wr(NCH + 1, 32'h0000_0000, "R7 resume ch9 only");

    // R8 enable rewrite without edge
    wr(NCH, 32'h0000_0000, "R8 disable again");
    wr(4, 32'h0000_0100, "R2 queue ch4");
    wr(NCH, 32'h0000_0000, "R8 no rise");
    wr(NCH, 32'h0000_0003, "R7 rise replays ch4");
    wr(NCH, 32'h0000_0001, "R8 still on no replay");
    rd(12, 32'h0, "R9 unmapped");
    rd(9, 32'h0000_0100, "R9 ch9 read");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule